// File: doc/BRIEF.md
# Three-Wire Synchronous Serial Port

This block moves one byte at a time over a three-line synchronous link: a data output, a data input and a shift clock. A single 8-bit shift register serves both directions, so while a byte leaves on the data output, the byte from the far end enters from the data input. The local processor writes the outgoing byte into the register, raises the start strobe to set the busy flag, and reads the received byte from the same register once busy has dropped.

The port can act as the clock owner or as the clock follower. As clock owner, it makes the shift clock from its own clock (the instruction clock) through a divider, and a two-bit select picks the divider. As clock follower, it takes the shift clock from the far end, synchronizes it and shifts on its edges. The most significant bit goes first. The output bit changes on the falling shift-clock edge and the input bit is sampled on the rising edge. At the end of the eighth bit, busy clears by itself. A one-cycle done pulse follows, and it also drives the interrupt line when interrupts are enabled. Chip selects are ordinary port pins outside this block.

Top module: `sser_port`

## Requirements
- R1: After reset, busy, done, irq, sk_out and sk_oe are 0 and rd_data is 8'h00.
- R2: While busy is 0, a load_we pulse writes load_data into the shift register, and rd_data shows it on the next cycle.
- R3: A start pulse while busy is 0 sets busy on the next cycle and latches master_mode and div_sel for the whole transfer. A start pulse while busy is 1 has no effect.
- R4: In master mode, div_sel 2'b00, 2'b01 and 2'b10 give a shift-clock period of 2, 4 and 8 clock cycles, and 2'b11 also gives 8. Busy therefore stays high for exactly 8 periods, counted from the clock edge that accepts start.
- R5: so carries bit 7 of the register first and moves to the next lower bit after each falling shift-clock edge. The bit on si is captured at each rising edge and enters at bit 0 on the following falling edge, so after the transfer rd_data holds the 8 received bits, the first one in bit 7.
- R6: On the edge that ends the eighth bit, busy goes to 0 and done goes to 1 for exactly one cycle. irq is 1 in that cycle only when irq_en is 1, and it is 0 at all other times.
- R7: A load_we pulse while busy is 1 is ignored, and the transfer's result in rd_data is not disturbed.
- R8: In slave mode, sk_in is synchronized and the register shifts on its rising and falling edges under the same bit rules as R5. sk_in edges have no effect while busy is 0.
- R9: sk_oe is 1 only while a master-mode transfer is busy, and sk_out is 0 whenever busy is 0 or the port is in slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction clock |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1 = drive the shift clock, 0 = follow sk_in |
| div_sel | input | 2 | Master clock divider select |
| irq_en | input | 1 | Lets done drive irq |
| load_we | input | 1 | Write strobe for the shift register |
| load_data | input | 8 | Byte to transmit |
| start | input | 1 | Sets busy and starts a transfer |
| rd_data | output | 8 | Shift register contents |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Completion interrupt request |
| so | output | 1 | Serial data out |
| si | input | 1 | Serial data in |
| sk_in | input | 1 | Shift clock from the far end (slave mode) |
| sk_out | output | 1 | Generated shift clock (master mode) |
| sk_oe | output | 1 | Drive enable for the shift clock pin |

## Verification
In master mode, busy falls and done rises 8·N clock edges after the edge that accepted start, where N is the divider ratio. The bench counts edges from that point at every falling clock edge and checks the exact count, then checks done, irq and rd_data in that same sample and checks that done is gone one sample later. In slave mode, each sk_in edge reaches the register after a three-cycle synchronizer delay, so the bench holds every sk_in level for six cycles before it samples so or rd_data. Every sample is taken at the falling clock edge, half a cycle away from the registers' updates.

// File: rtl/sser_pkg.sv
package sser_pkg;

    localparam int DATA_W    = 8;
    localparam int BIT_CNT_W = $clog2(DATA_W);
    localparam int SEL_W     = 2;
    localparam int MAX_SHIFT = 2;
    localparam int HC_W      = MAX_SHIFT;
    localparam int SYNC_LEN  = 2;

    typedef enum logic [SEL_W-1:0] {
        DIV_BY2     = 2'b00,
        DIV_BY4     = 2'b01,
        DIV_BY8     = 2'b10,
        DIV_BY8_ALT = 2'b11
    } div_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } sk_edge_t;

    function automatic logic [HC_W-1:0] half_limit(input div_sel_e sel);
        int sh;
        sh = (int'(sel) > MAX_SHIFT) ? MAX_SHIFT : int'(sel);
        return HC_W'((1 << sh) - 1);
    endfunction

endpackage

// File: rtl/sser_clkgen.sv
module sser_clkgen
    import sser_pkg::*;
#(
    parameter int HW = HC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [HW-1:0] limit,
    output logic          sk,
    output sk_edge_t      strobe
);

    logic [HW-1:0] hc;
    logic          tick;

    assign tick = run && (hc == limit);

    always_comb begin
        strobe.rise = tick && !sk;
        strobe.fall = tick && sk;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hc <= '0;
            sk <= 1'b0;
        end else if (tick) begin
            hc <= '0;
            sk <= !sk;
        end else begin
            hc <= hc + 1'b1;
        end
    end

endmodule

// File: rtl/sser_sync.sv
module sser_sync
    import sser_pkg::*;
#(
    parameter int STAGES = SYNC_LEN
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sk_raw,
    input  logic     si_raw,
    output sk_edge_t strobe,
    output logic     si_s
);

    logic [STAGES:0]   sk_pipe;
    logic [STAGES-1:0] si_pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            sk_pipe <= '0;
            si_pipe <= '0;
        end else begin
            sk_pipe <= {sk_pipe[STAGES-1:0], sk_raw};
            si_pipe <= {si_pipe[STAGES-2:0], si_raw};
        end
    end

    always_comb begin
        strobe.rise = sk_pipe[STAGES-1] && !sk_pipe[STAGES];
        strobe.fall = !sk_pipe[STAGES-1] && sk_pipe[STAGES];
    end

    assign si_s = si_pipe[STAGES-1];

endmodule

// File: rtl/sser_shifter.sv
module sser_shifter
    import sser_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = BIT_CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_we,
    input  logic [DW-1:0] load_data,
    input  logic          start,
    input  sk_edge_t      strobe,
    input  logic          si_bit,
    output logic [DW-1:0] sreg,
    output logic          busy,
    output logic          done
);

    localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

    logic [CW-1:0] bit_cnt;
    logic          cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg    <= '0;
            bit_cnt <= '0;
            cap     <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (load_we) sreg <= load_data;
                if (start) begin
                    busy    <= 1'b1;
                    bit_cnt <= '0;
                end
            end else begin
                if (strobe.rise) cap <= si_bit;
                if (strobe.fall) begin
                    sreg    <= {sreg[DW-2:0], cap};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/sser_port.sv
module sser_port
    import sser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              master_mode,
    input  logic [SEL_W-1:0]  div_sel,
    input  logic              irq_en,
    input  logic              load_we,
    input  logic [DATA_W-1:0] load_data,
    input  logic              start,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              irq,
    output logic              so,
    input  logic              si,
    input  logic              sk_in,
    output logic              sk_out,
    output logic              sk_oe
);

    logic      mode_q;
    div_sel_e  div_q;
    sk_edge_t  m_strobe, s_strobe, strobe;
    logic      si_sync, si_bit, m_sk;
    logic [HC_W-1:0] limit;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
            div_q  <= DIV_BY2;
        end else if (start && !busy) begin
            mode_q <= master_mode;
            div_q  <= div_sel_e'(div_sel);
        end
    end

    assign limit = half_limit(div_q);

    sser_clkgen #(.HW(HC_W)) u_clkgen (
        .clk    (clk),
        .rst    (rst),
        .run    (busy && mode_q),
        .limit  (limit),
        .sk     (m_sk),
        .strobe (m_strobe)
    );

    sser_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .sk_raw (sk_in),
        .si_raw (si),
        .strobe (s_strobe),
        .si_s   (si_sync)
    );

    assign strobe = mode_q ? m_strobe : s_strobe;
    assign si_bit = mode_q ? si : si_sync;

    sser_shifter #(.DW(DATA_W), .CW(BIT_CNT_W)) u_shifter (
        .clk       (clk),
        .rst       (rst),
        .load_we   (load_we),
        .load_data (load_data),
        .start     (start),
        .strobe    (strobe),
        .si_bit    (si_bit),
        .sreg      (rd_data),
        .busy      (busy),
        .done      (done)
    );

    assign so     = rd_data[DATA_W-1];
    assign irq    = done && irq_en;
    assign sk_out = m_sk && mode_q;
    assign sk_oe  = busy && mode_q;

endmodule

// File: rtl/sser_port_chk.sv
module sser_port_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic irq,
    input logic irq_en,
    input logic sk_out,
    input logic sk_oe
);

    a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_busy_fall_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r6_irq_gated: assert property (@(posedge clk) disable iff (rst)
        irq |-> (done && irq_en));

    a_r9_oe_only_busy: assert property (@(posedge clk) disable iff (rst)
        sk_oe |-> busy);

    a_r9_sk_low_idle: assert property (@(posedge clk) disable iff (rst)
        !sk_oe |-> !sk_out);

endmodule

bind sser_port sser_port_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .irq    (irq),
    .irq_en (irq_en),
    .sk_out (sk_out),
    .sk_oe  (sk_oe)
);

// File: tb/sser_port_bench.sv
`timescale 1ns/1ps
module sser_port_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       master_mode = 1'b1;
    logic [1:0] div_sel = 2'b00;
    logic       irq_en = 1'b0;
    logic       load_we = 1'b0;
    logic [7:0] load_data = 8'h00;
    logic       start = 1'b0;
    logic [7:0] rd_data;
    logic       busy, done, irq, so, sk_out, sk_oe;
    logic       si = 1'b0;
    logic       sk_in = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sser_port u_sser_port (
        .clk(clk), .rst(rst), .master_mode(master_mode), .div_sel(div_sel),
        .irq_en(irq_en), .load_we(load_we), .load_data(load_data),
        .start(start), .rd_data(rd_data), .busy(busy), .done(done),
        .irq(irq), .so(so), .si(si), .sk_in(sk_in), .sk_out(sk_out),
        .sk_oe(sk_oe)
    );

    typedef struct packed {
        logic [1:0] dsel;
        logic [7:0] tx;
        logic [7:0] rx;
        logic       ie;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{2'b00, 8'hA5, 8'h3C, 1'b1},
        '{2'b01, 8'h81, 8'h7E, 1'b0},
        '{2'b10, 8'hFF, 8'h00, 1'b1},
        '{2'b11, 8'h0F, 8'hF0, 1'b1},
        '{2'b00, 8'h00, 8'hFF, 1'b0}
    };

    // far-end model for master mode
    logic [7:0] cur_rx  = 8'h00;
    logic [7:0] so_cap  = 8'h00;
    int         bidx    = 0;
    bit         mon_on  = 0;

    always @(posedge sk_out) so_cap = {so_cap[6:0], so};
    always @(negedge sk_out) if (mon_on) begin
        bidx = bidx + 1;
        if (bidx < 8) si = cur_rx[7 - bidx];
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk); load_we = 1'b1; load_data = b;
        @(negedge clk); load_we = 1'b0;
    endtask

    task automatic run_master(input vec_t v, input bit disturb);
        int n;
        int exp_n;
        int sh;
        master_mode = 1'b1; div_sel = v.dsel; irq_en = v.ie;
        write_byte(v.tx);
        check("R2 load", rd_data, v.tx);
        cur_rx = v.rx; bidx = 0; so_cap = 8'h00; si = v.rx[7]; mon_on = 1;
        sh = (v.dsel > 2) ? 2 : v.dsel;
        exp_n = 16 << sh;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        n = 0;
        check("R3 busy after start", busy, 1);
        check("R9 sk_oe in master", sk_oe, 1);
        while (busy && n < 1000) begin
            if (disturb && n == 5) begin load_we = 1'b1; load_data = 8'h55; start = 1'b1; end
            else begin load_we = 1'b0; start = 1'b0; end
            @(negedge clk); n++;
            if (busy) check("R6 no early done", done, 0);
        end
        load_we = 1'b0; start = 1'b0;
        check("R4 transfer length", n, exp_n);
        check("R6 done at end", done, 1);
        check("R6 irq gating", irq, v.ie);
        check("R5 received byte", rd_data, v.rx);
        check("R5 sent byte msb first", so_cap, v.tx);
        if (disturb) check("R7 write while busy ignored", rd_data, v.rx);
        @(negedge clk);
        check("R6 done one cycle", done, 0);
        check("R6 irq low after", irq, 0);
        check("R9 sk_out idle low", sk_out, 0);
        mon_on = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] rec;
        logic [7:0] hold;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 irq", irq, 0);
        check("R1 sk_out", sk_out, 0);
        check("R1 sk_oe", sk_oe, 0);
        check("R1 rd_data", rd_data, 8'h00);

        // vector table, master mode (R4 R5 R6)
        foreach (VECS[i]) run_master(VECS[i], (i == 0));

        // R8 slave transfer
        master_mode = 1'b0; irq_en = 1'b1;
        write_byte(8'hC6);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R8 busy in slave", busy, 1);
        check("R9 no sk_oe in slave", sk_oe, 0);
        rec = 8'h00;
        for (int b = 0; b < 8; b++) begin
            si = 8'h9B >> (7 - b);
            repeat (6) @(negedge clk);
            rec = {rec[6:0], so};
            check("R9 sk_out quiet in slave", sk_out, 0);
            sk_in = 1'b1;
            repeat (6) @(negedge clk);
            sk_in = 1'b0;
        end
        repeat (6) @(negedge clk);
        check("R8 slave busy cleared", busy, 0);
        check("R8 slave received", rd_data, 8'h9B);
        check("R8 slave sent", rec, 8'hC6);

        // R8 sk_in edges ignored while idle
        hold = rd_data;
        si = 1'b0;
        for (int k = 0; k < 4; k++) begin
            sk_in = 1'b1; repeat (6) @(negedge clk);
            sk_in = 1'b0; repeat (6) @(negedge clk);
        end
        check("R8 idle edges ignored data", rd_data, hold);
        check("R8 idle edges ignored busy", busy, 0);

        // R2 idle write, then reset returns to R1 state
        write_byte(8'h3A);
        check("R2 idle write", rd_data, 8'h3A);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R1 rd_data after reset", rd_data, 8'h00);
        check("R1 busy after reset", busy, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule